// File: doc/BRIEF.md
# Per-Port Output Code Converter

This block takes the 8-bit unsigned result of each of three converter channels after they have been multiplexed onto their output ports. For each port it also takes a raw overrange and underrange indication. From these it builds the registered output byte and its flags. Each port picks its own coding through its own select line: straight binary, or two's complement, which is the binary code with the MSB inverted. The coding choice does not depend on the multiplex format.

An overrange input saturates the byte at the top code and sets the overflow flag. An underrange input saturates it at the bottom code and sets the underflow flag. One chip-level input marks the 4:2:2 multiplex format. While it is set, a port in binary coding never emits code 0 or code 255: they become 1 and 254. The substitution is made on the binary value, before any MSB inversion, so two's-complement ports are unaffected. Each port's output enable is registered in the same stage as its data. A disabled port shows zero data and zero flags, and its drive bit tells the pad ring to float the port.

Top module: `cc_code_conv`

## Requirements
- R1: While rst_ni is low, data_o, ovf_o, unf_o and drive_o are all zero.
- R2: A port that is enabled, in binary coding, and has neither range flag presents code_i on data_o exactly one clock after it is sampled.
- R3: With twos_i set for a port, its output equals the binary result with bit 7 inverted (binary 0 gives 8'h80, binary 255 gives 8'h7F).
- R4: over_i on an enabled port gives ovf_o = 1 and the top code one clock later: 8'hFF in binary, 8'h7F in two's complement. The flag appears in the same cycle as the byte it qualifies.
- R5: under_i on an enabled port gives unf_o = 1 and the bottom code one clock later: 8'h00 in binary, 8'h80 in two's complement.
- R6: When over_i and under_i are both set, overrange wins: ovf_o = 1, unf_o = 0, and the top code is output.
- R7: With fmt_422_i = 1 and binary coding, a result of 0 (including underflow saturation) is output as 8'h01, and a result of 255 (including overflow saturation) is output as 8'hFE. The range flags are still set.
- R8: With fmt_422_i = 1 and two's-complement coding, no suppression takes place: 8'h80 and 8'h7F still appear.
- R9: The coding select of one port has no effect on any other port's output.
- R10: When oe_i for a port is low, one clock later drive_o for that port is 0 and its data_o byte, ovf_o and unf_o are all 0. When oe_i is high, drive_o is 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_422_i | input | 1 | 4:2:2 multiplex format active (enables binary extreme-code suppression) |
| code_i | input | 24 | Unsigned result per port, port p at bits [8p+7:8p] |
| over_i | input | 3 | Raw overrange per port |
| under_i | input | 3 | Raw underrange per port |
| twos_i | input | 3 | Coding select per port, 1 = two's complement |
| oe_i | input | 3 | Output enable per port, active high |
| data_o | output | 24 | Registered output byte per port, same packing as code_i |
| ovf_o | output | 3 | Registered overflow flag per port |
| unf_o | output | 3 | Registered underflow flag per port |
| drive_o | output | 3 | Registered enable per port; 0 means the port floats |

## Verification
The bench targets the code-space extremes: inputs 0 and 255 with and without the 4:2:2 suppression, in both codings, and both range flags raised together. If suppression is applied after the MSB inversion, the codes 8'h80 and 8'h7F are wrongly rewritten. If suppression ignores the coding select, two's-complement ports lose their extreme codes. A design that lets underrange win a tie shows 8'h00 with the wrong flag. The bench mixes coding selects across the three ports to catch cross-port leakage. It toggles the enables to check that a disabled port goes quiet in the same cycle as its drive bit falls.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_MAX = '1;
  localparam code_t CODE_MIN = '0;
  localparam code_t MSB_MASK = code_t'(1) << (CODE_W - 1);
endpackage

// File: rtl/cc_port_coder.sv
module cc_port_coder
  import cc_pkg::*;
(
  input  code_t code_i,
  input  logic  over_i,
  input  logic  under_i,
  input  logic  twos_i,
  input  logic  fmt_422_i,
  output code_t data_o,
  output logic  ovf_o,
  output logic  unf_o
);
  code_t sat, sup;

  // overrange has priority over underrange
  always_comb begin
    ovf_o = over_i;
    unf_o = under_i & ~over_i;
    if (over_i)       sat = CODE_MAX;
    else if (under_i) sat = CODE_MIN;
    else              sat = code_i;
  end

  // suppression acts on the binary value, binary coding only
  always_comb begin
    sup = sat;
    if (fmt_422_i && !twos_i) begin
      if (sat == CODE_MIN)      sup = CODE_MIN + code_t'(1);
      else if (sat == CODE_MAX) sup = CODE_MAX - code_t'(1);
    end
  end

  assign data_o = twos_i ? (sup ^ MSB_MASK) : sup;
endmodule

// File: rtl/cc_out_reg.sv
module cc_out_reg
  import cc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  oe_i,
  input  code_t data_i,
  input  logic  ovf_i,
  input  logic  unf_i,
  output code_t data_o,
  output logic  ovf_o,
  output logic  unf_o,
  output logic  drive_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
      drive_o <= 1'b0;
    end else begin
      data_o  <= oe_i ? data_i : '0;
      ovf_o   <= oe_i & ovf_i;
      unf_o   <= oe_i & unf_i;
      drive_o <= oe_i;
    end
  end
endmodule

// File: rtl/cc_code_conv.sv
module cc_code_conv
  import cc_pkg::*;
#(
  parameter int unsigned NPORT = 3,
  localparam int unsigned BUS_W = NPORT * CODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fmt_422_i,
  input  logic [BUS_W-1:0] code_i,
  input  logic [NPORT-1:0] over_i,
  input  logic [NPORT-1:0] under_i,
  input  logic [NPORT-1:0] twos_i,
  input  logic [NPORT-1:0] oe_i,
  output logic [BUS_W-1:0] data_o,
  output logic [NPORT-1:0] ovf_o,
  output logic [NPORT-1:0] unf_o,
  output logic [NPORT-1:0] drive_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    code_t coded;
    code_t q_data;
    logic  c_ovf, c_unf;

    cc_port_coder u_coder (
      .code_i   (code_i[p*CODE_W +: CODE_W]),
      .over_i   (over_i[p]),
      .under_i  (under_i[p]),
      .twos_i   (twos_i[p]),
      .fmt_422_i(fmt_422_i),
      .data_o   (coded),
      .ovf_o    (c_ovf),
      .unf_o    (c_unf)
    );

    cc_out_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .oe_i   (oe_i[p]),
      .data_i (coded),
      .ovf_i  (c_ovf),
      .unf_i  (c_unf),
      .data_o (q_data),
      .ovf_o  (ovf_o[p]),
      .unf_o  (unf_o[p]),
      .drive_o(drive_o[p])
    );

    assign data_o[p*CODE_W +: CODE_W] = q_data;
  end
endmodule

// File: rtl/cc_code_conv_chk.sv
module cc_code_conv_chk #(
  parameter int unsigned NPORT = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fmt_422_i,
  input logic [NPORT*8-1:0] code_i,
  input logic [NPORT-1:0]   over_i,
  input logic [NPORT-1:0]   under_i,
  input logic [NPORT-1:0]   twos_i,
  input logic [NPORT-1:0]   oe_i,
  input logic [NPORT*8-1:0] data_o,
  input logic [NPORT-1:0]   ovf_o,
  input logic [NPORT-1:0]   unf_o,
  input logic [NPORT-1:0]   drive_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ovf_o[p] && unf_o[p])); // R6
    AST_OVF_TOP_BIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_i[p] && over_i[p] && !twos_i[p] && !fmt_422_i) |=>
        (ovf_o[p] && data_o[p*8 +: 8] == 8'hFF)); // R4
    AST_OVF_TOP_TWOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_i[p] && over_i[p] && twos_i[p]) |=>
        (ovf_o[p] && data_o[p*8 +: 8] == 8'h7F)); // R8
    AST_UNF_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_i[p] && under_i[p] && !over_i[p] && !twos_i[p] && !fmt_422_i) |=>
        (unf_o[p] && data_o[p*8 +: 8] == 8'h00)); // R5
    AST_NO_EXTREME_422: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_i[p] && fmt_422_i && !twos_i[p]) |=>
        (data_o[p*8 +: 8] != 8'h00 && data_o[p*8 +: 8] != 8'hFF)); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drive_o[p] |-> (data_o[p*8 +: 8] == 8'h00 && !ovf_o[p] && !unf_o[p])); // R10
    AST_DRIVE_FOLLOWS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_i[p] |=> drive_o[p]); // R10
  end
endmodule

bind cc_code_conv cc_code_conv_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/cc_code_conv_tb.sv
module cc_code_conv_tb;
  localparam int NP = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fmt = 1'b0;
  logic [NP*8-1:0] code = '0;
  logic [NP-1:0]   over = '0, under = '0, twos = '0, oe = '0;
  logic [NP*8-1:0] data;
  logic [NP-1:0]   ovf, unf, drive;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cc_code_conv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_422_i(fmt), .code_i(code),
    .over_i(over), .under_i(under), .twos_i(twos), .oe_i(oe),
    .data_o(data), .ovf_o(ovf), .unf_o(unf), .drive_o(drive)
  );

  function automatic logic [7:0] exp_byte(logic [7:0] c, logic ov, logic un,
                                          logic tw, logic f, logic en);
    logic [7:0] b;
    if (!en) return 8'h00;
    b = ov ? 8'hFF : (un ? 8'h00 : c);
    if (f && !tw) begin
      if (b == 8'h00) b = 8'h01;
      else if (b == 8'hFF) b = 8'hFE;
    end
    return tw ? {~b[7], b[6:0]} : b;
  endfunction

  function automatic string req_tag(logic [7:0] c, logic ov, logic un,
                                    logic tw, logic f, logic en);
    if (!en) return "R10";
    if (ov && un) return "R6";
    if (f && !tw && (ov || un || c == 8'h00 || c == 8'hFF)) return "R7";
    if (f && tw && (ov || un || c == 8'h00 || c == 8'hFF)) return "R8";
    if (ov) return "R4";
    if (un) return "R5";
    if (tw) return "R3";
    return "R2";
  endfunction

  // drive at negedge, sample at the following negedge (one register)
  task automatic step(string extra);
    logic [7:0] eb [NP];
    logic eo [NP];
    logic eu [NP];
    logic ed [NP];
    string tg [NP];
    for (int p = 0; p < NP; p++) begin
      eb[p] = exp_byte(code[p*8 +: 8], over[p], under[p], twos[p], fmt, oe[p]);
      eo[p] = oe[p] & over[p];
      eu[p] = oe[p] & under[p] & ~over[p];
      ed[p] = oe[p];
      tg[p] = req_tag(code[p*8 +: 8], over[p], under[p], twos[p], fmt, oe[p]);
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      n_tests++;
      if (data[p*8 +: 8] !== eb[p] || ovf[p] !== eo[p] || unf[p] !== eu[p] ||
          drive[p] !== ed[p]) begin
        n_fail++;
        $display("FAIL %s%s port %0d: data=%h ovf=%b unf=%b drv=%b expected data=%h ovf=%b unf=%b drv=%b",
                 tg[p], extra, p, data[p*8 +: 8], ovf[p], unf[p], drive[p],
                 eb[p], eo[p], eu[p], ed[p]);
      end
    end
  endtask

  task automatic set_port(int p, logic [7:0] c, logic ov, logic un, logic tw, logic en);
    code[p*8 +: 8] = c; over[p] = ov; under[p] = un; twos[p] = tw; oe[p] = en;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    // R1: reset state, inputs active during reset
    code = 24'hFF_80_01; over = '1; oe = '1; twos = 3'b101;
    repeat (3) @(negedge clk);
    n_tests++;
    if (data !== '0 || ovf !== '0 || unf !== '0 || drive !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: data=%h ovf=%b unf=%b drv=%b expected all zero",
               data, ovf, unf, drive);
    end
    rst_n = 1'b1;
    over = '0;

    // R2/R3 passthrough and MSB inversion
    fmt = 0;
    set_port(0, 8'h5A, 0, 0, 0, 1); set_port(1, 8'h5A, 0, 0, 1, 1); set_port(2, 8'h00, 0, 0, 1, 1);
    step(" directed");
    // R4/R5 saturation in both codings
    set_port(0, 8'h10, 1, 0, 0, 1); set_port(1, 8'h10, 1, 0, 1, 1); set_port(2, 8'hF0, 0, 1, 1, 1);
    step(" directed");
    set_port(0, 8'h80, 0, 1, 0, 1); set_port(1, 8'hFF, 0, 0, 1, 1); set_port(2, 8'hFF, 0, 0, 0, 1);
    step(" directed");
    // R6 both flags
    set_port(0, 8'h33, 1, 1, 0, 1); set_port(1, 8'h33, 1, 1, 1, 1); set_port(2, 8'h33, 1, 1, 0, 1);
    step(" directed");
    // R7 suppression in binary, R8 none in two's
    fmt = 1;
    set_port(0, 8'h00, 0, 0, 0, 1); set_port(1, 8'hFF, 0, 0, 0, 1); set_port(2, 8'h00, 0, 0, 1, 1);
    step(" directed");
    set_port(0, 8'h44, 1, 0, 0, 1); set_port(1, 8'h44, 0, 1, 0, 1); set_port(2, 8'hFF, 0, 0, 1, 1);
    step(" directed");
    set_port(0, 8'h02, 0, 0, 0, 1); set_port(1, 8'h44, 1, 0, 1, 1); set_port(2, 8'h44, 0, 1, 1, 1);
    step(" directed");
    // R9 mixed selects on identical inputs
    fmt = 0;
    set_port(0, 8'hC3, 0, 0, 0, 1); set_port(1, 8'hC3, 0, 0, 1, 1); set_port(2, 8'hC3, 0, 0, 0, 1);
    step(" R9 directed");
    // R10 disabled port, neighbours enabled
    set_port(0, 8'hC3, 1, 0, 0, 1); set_port(1, 8'hFF, 1, 0, 0, 0); set_port(2, 8'h77, 0, 1, 1, 1);
    step(" directed");
    set_port(1, 8'h12, 0, 0, 0, 1);
    step(" directed");

    // constrained random, extremes weighted
    for (int i = 0; i < 3000; i++) begin
      fmt = ($urandom % 3) == 0;
      for (int p = 0; p < NP; p++) begin
        int sel;
        logic [7:0] c;
        sel = $urandom % 8;
        c = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : 8'($urandom);
        set_port(p, c, ($urandom % 6) == 0, ($urandom % 6) == 0,
                 1'($urandom), ($urandom % 8) != 0);
      end
      step(" random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule